// File: doc/BRIEF.md
# Supply Fault Timer and Restart Sequencer

This block is the supply-management state machine of a switching power controller. It watches digital flags from comparators on the controller's own supply rail at four levels: turn-on, undervoltage, latch-end and reset. It also watches a maximum-current error flag, an over-threshold flag from the current-sense pin (qualified by a switch off-time indication) and a thermal flag. From these it decides when the high-voltage startup current source charges the supply, when gate drive runs, when a soft-start ramp is launched, and when the block drops into a low-consumption phase.

A sustained maximum-current condition is timed by a cycle-count window, and only a condition that outlasts the window stops the drive. After a supply-side fault, the sequencer lets the supply discharge to the undervoltage level and then to the latch-end level. It then recharges, and it allows a restart only on every second charge cycle, which halves the average power delivered into a fault. A sense-pin over-threshold or a thermal event instead locks the drive off permanently. Only a collapse of the supply below the reset level clears that lock, and this collapse also returns every other state to the initial charging state.

Top module: `supply_seq`

## Requirements
- R1: After reset, with the supply below the reset level, the startup source is enabled (hv_en_o=1), drive is off, low_pwr_o=0, fault_o=0 and ss_active_o=0.
- R2: In the charging state, a high turn-on flag makes the next edge disable the startup source and enable drive. ss_trig_o pulses for exactly that one cycle, and ss_active_o stays high for SS_CYC cycles counted from that edge.
- R3: If ilim_i is high on FAULT_CYC consecutive clock edges while driving, drive stops on the FAULT_CYC-th edge. fault_o becomes 1 (supply fault), the startup source stays off and low_pwr_o stays 0.
- R4: If ilim_i drops before the window completes, the count restarts, and a new assertion again needs the full FAULT_CYC edges before drive stops.
- R5: While driving, a low undervoltage flag stops drive on the next edge without waiting for the timer. It enters the latch-off phase with low_pwr_o=1 and fault_o=1.
- R6: In the latch-off phase, a low latch-end flag re-enables the startup source and clears low_pwr_o on the next edge.
- R7: After a supply fault, the first time the recharging supply reaches turn-on, the startup source turns off with no drive and the sequencer waits for a new undervoltage fall. The second time, drive restarts with a fresh soft-start pulse and fault_o returns to 0.
- R8: While driving, cs_over_i together with sw_off_i stops drive on the next edge with fault_o=2. The lock then holds whatever the other flags do, until the reset flag goes low.
- R9: cs_over_i without sw_off_i has no effect: drive continues and fault_o stays 0.
- R10: While driving, therm_i stops drive on the next edge with fault_o=3, and the lock holds until the reset flag goes low.
- R11: A low reset flag returns the block from any state to charging on the next edge (hv_en_o=1, drive off, fault_o=0). It also clears the divide-by-two count, so the next turn-on drives directly.
- R12: When several stop conditions arrive in the same cycle, the sense latch wins over thermal, thermal over undervoltage, and undervoltage over timer expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_uv_i | input | 1 | Supply above undervoltage level |
| vcc_latch_i | input | 1 | Supply above latch-end level |
| vcc_rst_i | input | 1 | Supply above reset level |
| ilim_i | input | 1 | Maximum-current error flag |
| cs_over_i | input | 1 | Current-sense pin above latch threshold |
| sw_off_i | input | 1 | Power switch is in its off-time |
| therm_i | input | 1 | Over-temperature flag |
| hv_en_o | output | 1 | High-voltage startup current source enable |
| drv_en_o | output | 1 | Gate drive enable |
| ss_trig_o | output | 1 | One-cycle soft-start launch pulse |
| ss_active_o | output | 1 | Soft-start interval in progress |
| low_pwr_o | output | 1 | Low-consumption latch-off phase |
| fault_o | output | 2 | Fault status: 0 none, 1 supply, 2 sense latch, 3 thermal |

## Verification
The bench places the edge where the overload window completes exactly. It also breaks the window one edge short, so a counter that fails to clear, or that is off by one, stops drive early or late. It walks two complete discharge and recharge loops, which catches a divide-by-two that restarts on the first charge or never restarts, and it checks that a reset-level collapse clears that count. It holds the permanent lock against every other flag, checks that an ungated sense flag is ignored, and raises stop conditions together so that a wrong priority shows up as the wrong fault code or the wrong low-power state.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
  typedef enum logic [2:0] {
    ST_CHARGE,
    ST_RUN,
    ST_DRAIN,
    ST_LATCHOFF,
    ST_RECHARGE,
    ST_LOCK
  } seq_state_t;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_SUPPLY = 2'd1,
    FLT_SENSE  = 2'd2,
    FLT_THERM  = 2'd3
  } fault_t;
endpackage

// File: rtl/seq_fault_timer.sv
module seq_fault_timer #(
  parameter int FAULT_CYC = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(FAULT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FAULT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm_i) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expire_o = arm_i && (cnt == LAST);

  // R4: a dropped flag restarts the window from zero
  a_r4_window_restart: assert property (@(posedge clk) disable iff (rst)
    !arm_i |=> !expire_o);
endmodule

// File: rtl/seq_softstart.sv
module seq_softstart #(
  parameter int SS_CYC = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic hold_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(SS_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start_i) cnt <= CNT_W'(SS_CYC);
    else if (!hold_i) cnt <= '0;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active_o = (cnt != '0);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import supply_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   vcc_on_i,
  input  logic   vcc_uv_i,
  input  logic   vcc_latch_i,
  input  logic   vcc_rst_i,
  input  logic   cs_over_i,
  input  logic   sw_off_i,
  input  logic   therm_i,
  input  logic   expire_i,
  output logic   hv_en_o,
  output logic   drv_en_o,
  output logic   low_pwr_o,
  output logic   ss_trig_o,
  output logic   enter_run_o,
  output fault_t fault_o
);
  seq_state_t state, nxt;
  fault_t     nflt;
  logic       skip, nskip;

  always_comb begin
    nxt   = state;
    nflt  = fault_o;
    nskip = skip;
    if (!vcc_rst_i) begin
      nxt   = ST_CHARGE;
      nflt  = FLT_NONE;
      nskip = 1'b0;
    end else begin
      case (state)
        ST_CHARGE: if (vcc_on_i) nxt = ST_RUN;
        ST_RUN: begin
          if (cs_over_i && sw_off_i) begin
            nxt  = ST_LOCK;
            nflt = FLT_SENSE;
          end else if (therm_i) begin
            nxt  = ST_LOCK;
            nflt = FLT_THERM;
          end else if (!vcc_uv_i) begin
            nxt  = ST_LATCHOFF;
            nflt = FLT_SUPPLY;
          end else if (expire_i) begin
            nxt  = ST_DRAIN;
            nflt = FLT_SUPPLY;
          end
        end
        ST_DRAIN:    if (!vcc_uv_i) nxt = ST_LATCHOFF;
        ST_LATCHOFF: if (!vcc_latch_i) nxt = ST_RECHARGE;
        ST_RECHARGE: begin
          if (vcc_on_i) begin
            if (skip) begin
              nxt   = ST_RUN;
              nskip = 1'b0;
            end else begin
              nxt   = ST_DRAIN;
              nskip = 1'b1;
            end
          end
        end
        ST_LOCK: nxt = ST_LOCK;
        default: nxt = ST_CHARGE;
      endcase
    end
    enter_run_o = (nxt == ST_RUN) && (state != ST_RUN);
    if (enter_run_o) nflt = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CHARGE;
      fault_o   <= FLT_NONE;
      skip      <= 1'b0;
      hv_en_o   <= 1'b1;
      drv_en_o  <= 1'b0;
      low_pwr_o <= 1'b0;
      ss_trig_o <= 1'b0;
    end else begin
      state     <= nxt;
      fault_o   <= nflt;
      skip      <= nskip;
      hv_en_o   <= (nxt == ST_CHARGE) || (nxt == ST_RECHARGE);
      drv_en_o  <= (nxt == ST_RUN);
      low_pwr_o <= (nxt == ST_LATCHOFF);
      ss_trig_o <= enter_run_o;
    end
  end

  // R3: a supply fault with the rail still healthy comes from timer expiry
  a_r3_timeout_stop: assert property (@(posedge clk) disable iff (rst)
    ($fell(drv_en_o) && fault_o == FLT_SUPPLY && !low_pwr_o) |-> $past(expire_i));

  // R8 / R10: the permanent lock holds while the supply stays above reset
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && vcc_rst_i) |=> (state == ST_LOCK && !drv_en_o && !hv_en_o));

  // R11: reset-level collapse overrides everything
  a_r11_reset_override: assert property (@(posedge clk) disable iff (rst)
    !vcc_rst_i |=> (hv_en_o && !drv_en_o && fault_o == FLT_NONE));

  // R5: latch-off phase never charges or drives
  a_r5_lowpwr_quiet: assert property (@(posedge clk) disable iff (rst)
    low_pwr_o |-> (!hv_en_o && !drv_en_o));
endmodule

// File: rtl/supply_seq.sv
module supply_seq #(
  parameter int FAULT_CYC = 125000,
  parameter int SS_CYC    = 2500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_on_i,
  input  logic       vcc_uv_i,
  input  logic       vcc_latch_i,
  input  logic       vcc_rst_i,
  input  logic       ilim_i,
  input  logic       cs_over_i,
  input  logic       sw_off_i,
  input  logic       therm_i,
  output logic       hv_en_o,
  output logic       drv_en_o,
  output logic       ss_trig_o,
  output logic       ss_active_o,
  output logic       low_pwr_o,
  output logic [1:0] fault_o
);
  import supply_seq_pkg::*;

  logic   expire;
  logic   enter_run;
  fault_t fault;

  seq_fault_timer #(.FAULT_CYC(FAULT_CYC)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (drv_en_o && ilim_i),
    .expire_o (expire)
  );

  seq_softstart #(.SS_CYC(SS_CYC)) ss_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (enter_run),
    .hold_i   (drv_en_o),
    .active_o (ss_active_o)
  );

  seq_fsm fsm_i (
    .clk         (clk),
    .rst         (rst),
    .vcc_on_i    (vcc_on_i),
    .vcc_uv_i    (vcc_uv_i),
    .vcc_latch_i (vcc_latch_i),
    .vcc_rst_i   (vcc_rst_i),
    .cs_over_i   (cs_over_i),
    .sw_off_i    (sw_off_i),
    .therm_i     (therm_i),
    .expire_i    (expire),
    .hv_en_o     (hv_en_o),
    .drv_en_o    (drv_en_o),
    .low_pwr_o   (low_pwr_o),
    .ss_trig_o   (ss_trig_o),
    .enter_run_o (enter_run),
    .fault_o     (fault)
  );

  assign fault_o = fault;

  // R2: every drive start comes with a soft-start launch
  a_r2_ss_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en_o) |-> (ss_trig_o && ss_active_o));
endmodule

// File: tb/supply_seq_tb_top.sv
module supply_seq_tb_top;
  localparam int F = 20;
  localparam int S = 8;
  localparam int L_ZERO = 0, L_RST = 1, L_LE = 2, L_UV = 3, L_ON = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_on = 0, vcc_uv = 0, vcc_latch = 0, vcc_rst = 0;
  logic ilim = 0, cs_over = 0, sw_off = 0, therm = 0;
  logic hv_en, drv_en, ss_trig, ss_active, low_pwr;
  logic [1:0] fault;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  supply_seq #(.FAULT_CYC(F), .SS_CYC(S)) dut_i (
    .clk(clk), .rst(rst),
    .vcc_on_i(vcc_on), .vcc_uv_i(vcc_uv), .vcc_latch_i(vcc_latch), .vcc_rst_i(vcc_rst),
    .ilim_i(ilim), .cs_over_i(cs_over), .sw_off_i(sw_off), .therm_i(therm),
    .hv_en_o(hv_en), .drv_en_o(drv_en), .ss_trig_o(ss_trig), .ss_active_o(ss_active),
    .low_pwr_o(low_pwr), .fault_o(fault)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_vcc(input int lvl);
    vcc_rst   = (lvl >= L_RST);
    vcc_latch = (lvl >= L_LE);
    vcc_uv    = (lvl >= L_UV);
    vcc_on    = (lvl >= L_ON);
  endtask

  // packed view: {hv, drv, low, fault[1:0]}
  function automatic logic [4:0] outs();
    return {hv_en, drv_en, low_pwr, fault};
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clear_misc();
    ilim = 0; cs_over = 0; sw_off = 0; therm = 0;
  endtask

  task automatic go_run();
    clear_misc();
    set_vcc(L_ZERO); step(1);
    set_vcc(L_ON);   step(1);
  endtask

  task automatic t_reset_state();
    check("R1 reset outputs", outs(), 5'b10000);
    check("R1 soft-start idle", {4'b0, ss_active}, 5'b0);
  endtask

  task automatic t_power_up();
    clear_misc();
    set_vcc(L_RST); step(1);
    set_vcc(L_UV);  step(1);
    check("R2 below turn-on keeps charging", outs(), 5'b10000);
    set_vcc(L_ON);  step(1);
    check("R2 drive starts", outs(), 5'b01000);
    check("R2 trigger pulse", {3'b0, ss_trig, ss_active}, 5'b00011);
    step(1);
    check("R2 trigger one cycle", {3'b0, ss_trig, ss_active}, 5'b00001);
    step(S - 2);
    check("R2 soft-start last cycle", {4'b0, ss_active}, 5'b00001);
    step(1);
    check("R2 soft-start ended", {4'b0, ss_active}, 5'b00000);
  endtask

  task automatic t_overload_window();
    go_run();
    ilim = 1; step(F - 1);
    check("R4 short burst keeps drive", outs(), 5'b01000);
    ilim = 0; step(1);
    ilim = 1; step(F - 1);
    check("R4 window restarted", outs(), 5'b01000);
    step(1);
    check("R3 timeout stops drive", outs(), 5'b00001);
    ilim = 0;
  endtask

  task automatic t_divide_restart();
    // continues from the drained state left by the overload test
    set_vcc(L_LE); step(1);
    check("R5 undervoltage enters latch-off", outs(), 5'b00101);
    set_vcc(L_RST); step(1);
    check("R6 latch-end re-enables source", outs(), 5'b10001);
    set_vcc(L_ON); step(1);
    check("R7 first charge skips restart", outs(), 5'b00001);
    check("R7 no trigger on skipped charge", {4'b0, ss_trig}, 5'b0);
    set_vcc(L_LE); step(1);
    check("R7 second latch-off", outs(), 5'b00101);
    set_vcc(L_RST); step(1);
    set_vcc(L_ON); step(1);
    check("R7 second charge restarts", outs(), 5'b01000);
    check("R7 restart trigger", {4'b0, ss_trig}, 5'b00001);
  endtask

  task automatic t_undervoltage();
    go_run();
    set_vcc(L_LE); step(1);
    check("R5 immediate stop on undervoltage", outs(), 5'b00101);
  endtask

  task automatic t_sense_latch();
    go_run();
    cs_over = 1; sw_off = 0; step(3);
    check("R9 ungated sense ignored", outs(), 5'b01000);
    sw_off = 1; step(1);
    check("R8 sense latch", outs(), 5'b00010);
    cs_over = 0; sw_off = 0; ilim = 1; step(F + 2);
    set_vcc(L_LE); step(2);
    set_vcc(L_RST); step(2);
    set_vcc(L_ON); step(2);
    check("R8 lock holds", outs(), 5'b00010);
    ilim = 0;
    set_vcc(L_ZERO); step(1);
    check("R11 reset clears sense lock", outs(), 5'b10000);
  endtask

  task automatic t_thermal();
    go_run();
    therm = 1; step(1);
    check("R10 thermal stop", outs(), 5'b00011);
    therm = 0; set_vcc(L_RST); step(3);
    set_vcc(L_ON); step(2);
    check("R10 thermal lock holds", outs(), 5'b00011);
    set_vcc(L_ZERO); step(1);
    check("R11 reset clears thermal lock", outs(), 5'b10000);
  endtask

  task automatic t_reset_override();
    go_run();
    ilim = 1; step(F);
    ilim = 0;
    set_vcc(L_LE); step(1);
    set_vcc(L_RST); step(1);
    set_vcc(L_ON); step(1);
    check("R7 skipped charge before override", outs(), 5'b00001);
    set_vcc(L_ZERO); step(1);
    check("R11 override from drained", outs(), 5'b10000);
    set_vcc(L_ON); step(1);
    check("R11 divide count cleared", outs(), 5'b01000);
  endtask

  task automatic t_priority();
    go_run();
    cs_over = 1; sw_off = 1; therm = 1; step(1);
    check("R12 sense over thermal", outs(), 5'b00010);
    go_run();
    therm = 1; set_vcc(L_LE); step(1);
    check("R12 thermal over undervoltage", outs(), 5'b00011);
    go_run();
    ilim = 1; step(F - 1);
    set_vcc(L_LE); step(1);
    check("R12 undervoltage over timeout", outs(), 5'b00101);
    clear_misc();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 0;
    #1;
    t_reset_state();
    t_power_up();
    t_overload_window();
    t_divide_restart();
    t_undervoltage();
    t_sense_latch();
    t_thermal();
    t_reset_override();
    t_priority();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule